// File: doc/BRIEF.md
# Single-Cycle 32-Bit Integer Loop Processor

This block is a compact processor core that completes one instruction per clock. It runs short, register-only loop programs such as arithmetic kernels, bit tests and shift-and-subtract searches. Its program is a fixed image of up to 128 instruction words, given to the core as a parameter when it is instantiated. The core fetches the word addressed by the program counter and decodes it. It reads two operands from a 32-entry register file and forms the result in an arithmetic unit. The result is written back, and the next program counter is chosen, all at the same rising edge.

The instruction set is small: three-register add, subtract, and, or, signed set-less-than and one-bit logical shifts, plus immediate forms (add, subtract, and, or, load-upper) and two conditional branches. There is no data memory and no delayed branch slot. Any word the decoder does not know is passed over as a no-op. A program ends by branching to its own address, which parks the program counter.

Software never touches the core. A test environment watches it through three outputs: the program counter, the instruction word being executed, and a combinational read of any register chosen by a select input.

Top module: `loop_core`

## Requirements
- R1: While reset is low the program counter is 0, the instruction output shows image word 0, and every register reads 0.
- R2: An instruction that is not a taken branch advances the program counter by exactly 4 at the next rising edge.
- R3: Opcode 0 with function codes 0x20 (add), 0x22 (sub), 0x24 (and) and 0x25 (or) writes rs op rt into rd (bits 15:11). Add and subtract wrap modulo 2^32 without any trap.
- R4: Opcode 0 with function 0x2A writes 1 into rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R5: Opcode 0 with function 0x00 shifts rt left, and function 0x02 shifts rt right logically, by exactly one bit into rd. The shift-amount field (bits 10:6) is ignored.
- R6: Immediate forms write rt (bits 20:16). Opcodes 0x08 (add) and 0x18 (subtract) sign-extend bits 15:0. Opcodes 0x0C (and) and 0x0D (or) zero-extend them. Opcode 0x0F puts them in bits 31:16 with zeros below.
- R7: Opcodes 0x04 (branch if rs equals rt) and 0x05 (branch if they differ) load PC+4 plus the sign-extended offset times 4 when taken, and PC+4 otherwise. The word after a branch is never executed on the taken path.
- R8: A taken branch whose offset is -1 keeps the program counter at its own address on every following clock.
- R9: Register 0 reads as 0 at all times, and writes to it are dropped.
- R10: Any other opcode, including the load and store opcodes 0x23 and 0x2B, and any other function code under opcode 0, writes no register and advances the program counter by 4.
- R11: The instruction output equals the image word at PC bits 8:2. The debug data output equals the register picked by the select input, combinationally.
- R12: A binary greatest-common-divisor loop built only from these instructions leaves the correct divisor in register 8 and zero in registers 9 and 10 when it halts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgSel | input | 5 | Register number to show on dbgData |
| pcOut | output | 32 | Current program counter |
| instrOut | output | 32 | Instruction word at the current program counter |
| dbgData | output | 32 | Contents of the register chosen by dbgSel |

## Verification
Two functions share one cycle when an instruction reads a register that the previous instruction wrote. Another case is an instruction that reads and overwrites the same register, so the operand fetch and the write-back meet at one edge. The test program provokes both. An add-immediate increments a register in place. The very next instruction is a branch that tests that register against zero. The test is judged through the program counter: the bench samples it one cycle later and it must show the taken target, not the fall-through address. The final register value is read back through the debug port to confirm the in-place increment.

// File: rtl/loop_core_pkg.sv
package loop_core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_SUBI  = 6'h18;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT,
    ALU_SLL1,
    ALU_SRL1,
    ALU_PASSB
  } aluOpE;

  typedef enum logic [1:0] {
    EXT_SIGN,
    EXT_ZERO,
    EXT_HIGH
  } extModeE;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic    regWrite;
    logic    useImm;
    logic    dstRt;
    extModeE extMode;
    aluOpE   aluOp;
    logic    branchEq;
    logic    branchNe;
  } ctrlS;

endpackage

// File: rtl/loop_core_alu.sv
module loop_core_alu
  import loop_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluOpE             aluOp,
  output logic [DATA_W-1:0] aluY
);

  always_comb begin
    case (aluOp)
      ALU_ADD:   aluY = opA + opB;
      ALU_SUB:   aluY = opA - opB;
      ALU_AND:   aluY = opA & opB;
      ALU_OR:    aluY = opA | opB;
      ALU_SLT:   aluY = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_SLL1:  aluY = {opB[DATA_W-2:0], 1'b0};
      ALU_SRL1:  aluY = {1'b0, opB[DATA_W-1:1]};
      ALU_PASSB: aluY = opB;
      default:   aluY = '0;
    endcase
  end

endmodule

// File: rtl/loop_core_regfile.sv
module loop_core_regfile #(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int REG_AW   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  input  logic [REG_AW-1:0] rdAddrDbg,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] rdDataDbg
);

  logic [DATA_W-1:0] regs [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : genEntry
    if (g == 0) begin : genZero
      assign regs[g] = '0;
    end else begin : genReg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                q <= '0;
        else if (wrEn && wrAddr == REG_AW'(g))    q <= wrData;
      end
      assign regs[g] = q;
    end
  end

  assign rdDataA   = regs[rdAddrA];
  assign rdDataB   = regs[rdAddrB];
  assign rdDataDbg = regs[rdAddrDbg];

  // R3: a write to a nonzero register is visible in that register after the edge
  assert_writeback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=> regs[$past(wrAddr)] == $past(wrData));

endmodule

// File: rtl/loop_core_control.sv
module loop_core_control
  import loop_core_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlS       ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.extMode = EXT_SIGN;
    ctrl.aluOp   = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regWrite = 1'b1;
        case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          FN_SLL:  ctrl.aluOp = ALU_SLL1;
          FN_SRL:  ctrl.aluOp = ALU_SRL1;
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.dstRt    = 1'b1;
        case (opcode)
          OP_SUBI: ctrl.aluOp = ALU_SUB;
          OP_ANDI: begin ctrl.aluOp = ALU_AND;   ctrl.extMode = EXT_ZERO; end
          OP_ORI:  begin ctrl.aluOp = ALU_OR;    ctrl.extMode = EXT_ZERO; end
          OP_LUI:  begin ctrl.aluOp = ALU_PASSB; ctrl.extMode = EXT_HIGH; end
          default: ctrl.aluOp = ALU_ADD;
        endcase
      end
      OP_BEQ:  ctrl.branchEq = 1'b1;
      OP_BNE:  ctrl.branchNe = 1'b1;
      default: ;
    endcase
  end

  logic knownOp;
  assign knownOp = opcode inside {OP_RTYPE, OP_BEQ, OP_BNE, OP_ADDI,
                                  OP_SUBI, OP_ANDI, OP_ORI, OP_LUI};

  // R10: an unknown opcode raises no write and no branch strobe
  assert_unknown_noop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !knownOp |-> (!ctrl.regWrite && !ctrl.branchEq && !ctrl.branchNe));

  // R7: the two branch strobes never coincide
  assert_branch_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.branchEq && ctrl.branchNe));

endmodule

// File: rtl/loop_core_datapath.sv
module loop_core_datapath
  import loop_core_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROM_WORDS = 128,
  parameter int REG_COUNT = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0,
  parameter logic [ROM_WORDS*32-1:0] ROM_IMAGE = '0,
  localparam int REG_AW = $clog2(REG_COUNT),
  localparam int ROM_AW = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlS              ctrl,
  input  logic [REG_AW-1:0] dbgSel,
  output logic [31:0]       instr,
  output logic [DATA_W-1:0] dbgData,
  output logic [DATA_W-1:0] pc
);

  // Fetch
  logic [ROM_AW-1:0] romIdx;
  assign romIdx = pc[ROM_AW+1:2];
  assign instr  = ROM_IMAGE[32*int'(romIdx) +: 32];

  logic [REG_AW-1:0] rsAddr, rtAddr, rdAddr, wrAddr;
  logic [15:0]       immRaw;
  assign rsAddr = instr[21 +: REG_AW];
  assign rtAddr = instr[16 +: REG_AW];
  assign rdAddr = instr[11 +: REG_AW];
  assign immRaw = instr[15:0];

  // Immediate extension
  logic [DATA_W-1:0] immSext, immExt;
  assign immSext = {{(DATA_W-16){immRaw[15]}}, immRaw};
  always_comb begin
    case (ctrl.extMode)
      EXT_ZERO: immExt = {{(DATA_W-16){1'b0}}, immRaw};
      EXT_HIGH: immExt = {immRaw, {(DATA_W-16){1'b0}}};
      default:  immExt = immSext;
    endcase
  end

  // Operands and execute
  logic [DATA_W-1:0] rsData, rtData, aluB, aluY;
  assign wrAddr = ctrl.dstRt ? rtAddr : rdAddr;
  assign aluB   = ctrl.useImm ? immExt : rtData;

  loop_core_regfile #(
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
  ) u_regfile (
    .clk       (clk),
    .rstN      (rstN),
    .rdAddrA   (rsAddr),
    .rdAddrB   (rtAddr),
    .rdAddrDbg (dbgSel),
    .wrEn      (ctrl.regWrite),
    .wrAddr    (wrAddr),
    .wrData    (aluY),
    .rdDataA   (rsData),
    .rdDataB   (rtData),
    .rdDataDbg (dbgData)
  );

  loop_core_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .opA   (rsData),
    .opB   (aluB),
    .aluOp (ctrl.aluOp),
    .aluY  (aluY)
  );

  // Next program counter
  logic              operandsEqual, branchTaken;
  logic [DATA_W-1:0] pcPlus4, branchOff, pcNext;
  assign operandsEqual = (rsData == rtData);
  assign branchTaken   = (ctrl.branchEq && operandsEqual) ||
                         (ctrl.branchNe && !operandsEqual);
  assign pcPlus4       = pc + DATA_W'(4);
  assign branchOff     = {immSext[DATA_W-3:0], 2'b00};
  assign pcNext        = branchTaken ? (pcPlus4 + branchOff) : pcPlus4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= RESET_PC;
    else       pc <= pcNext;
  end

  // R2: no taken branch means a step of four
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !branchTaken |=> pc == $past(pc) + DATA_W'(4));

  // R7: a taken branch lands on PC+4 plus the scaled offset
  assert_branch_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |=> pc == $past(pc) + DATA_W'(4) + $past(branchOff));

  // R8: a taken self-branch parks the program counter
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken && immRaw == 16'hFFFF) |=> $stable(pc));

  // R4: a compare result is a single bit
  assert_slt_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluOp == ALU_SLT && ctrl.regWrite) |-> aluY[DATA_W-1:1] == '0);

endmodule

// File: rtl/loop_core.sv
module loop_core
  import loop_core_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROM_WORDS = 128,
  parameter int REG_COUNT = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0,
  parameter logic [ROM_WORDS*32-1:0] ROM_IMAGE = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(REG_COUNT)-1:0] dbgSel,
  output logic [DATA_W-1:0]            pcOut,
  output logic [31:0]                  instrOut,
  output logic [DATA_W-1:0]            dbgData
);

  ctrlS        ctrl;
  logic [31:0] instr;

  loop_core_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  loop_core_datapath #(
    .DATA_W    (DATA_W),
    .ROM_WORDS (ROM_WORDS),
    .REG_COUNT (REG_COUNT),
    .RESET_PC  (RESET_PC),
    .ROM_IMAGE (ROM_IMAGE)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .dbgSel  (dbgSel),
    .instr   (instr),
    .dbgData (dbgData),
    .pc      (pcOut)
  );

  assign instrOut = instr;

endmodule

// File: tb/loop_core_tb.sv
`timescale 1ns/1ps
module loop_core_tb;

  localparam int ROM_WORDS = 128;
  localparam int T0 = 8, T1 = 9, T2 = 10, T3 = 11, T4 = 12;
  localparam logic [31:0] GCD_A = 32'd554400;
  localparam logic [31:0] GCD_B = 32'd655200;
  localparam logic [31:0] HALT_PC = 32'd244;  // word 61

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] encB(logic [5:0] op, int rs, int rt, int off);
    logic [31:0] o;
    o = off;
    return encI(op, rs, rt, o[15:0]);
  endfunction

  function automatic logic [ROM_WORDS*32-1:0] buildImage();
    logic [ROM_WORDS*32-1:0] img;
    int k;
    img = '0;
    k = 0;
    img[32*k +: 32] = encI(6'h0F, 0, 16, 16'h8000);        k++; // 0 lui
    img[32*k +: 32] = encI(6'h0D, 16, 16, 16'h00F0);       k++; // 1 ori
    img[32*k +: 32] = encI(6'h08, 0, 17, 16'hFFFB);        k++; // 2 addi -5
    img[32*k +: 32] = encI(6'h0C, 17, 18, 16'hFFFF);       k++; // 3 andi
    img[32*k +: 32] = encR(16, 17, 19, 0, 6'h2A);          k++; // 4 slt
    img[32*k +: 32] = encR(18, 17, 20, 0, 6'h2A);          k++; // 5 slt
    img[32*k +: 32] = encR(0, 16, 21, 7, 6'h02);           k++; // 6 srl, shamt 7
    img[32*k +: 32] = encR(0, 16, 22, 5, 6'h00);           k++; // 7 sll, shamt 5
    img[32*k +: 32] = encI(6'h18, 18, 23, 16'h0003);       k++; // 8 subi
    img[32*k +: 32] = encR(17, 18, 24, 0, 6'h24);          k++; // 9 and
    img[32*k +: 32] = encR(16, 18, 25, 0, 6'h25);          k++; // 10 or
    img[32*k +: 32] = encR(0, 18, 26, 0, 6'h22);           k++; // 11 sub
    img[32*k +: 32] = encR(16, 16, 27, 0, 6'h20);          k++; // 12 add wraps
    img[32*k +: 32] = encI(6'h08, 0, 0, 16'h0007);         k++; // 13 write r0
    img[32*k +: 32] = encI(6'h23, 0, 29, 16'h0000);        k++; // 14 load opcode
    img[32*k +: 32] = encI(6'h3F, 0, 29, 16'h0001);        k++; // 15 unknown
    img[32*k +: 32] = encB(6'h05, 19, 20, 1);              k++; // 16 bne taken
    img[32*k +: 32] = encI(6'h08, 0, 29, 16'h0001);        k++; // 17 skipped
    img[32*k +: 32] = encB(6'h04, 20, 0, 1);               k++; // 18 beq taken
    img[32*k +: 32] = encI(6'h08, 0, 29, 16'h0002);        k++; // 19 skipped
    img[32*k +: 32] = encB(6'h04, 19, 0, 1);               k++; // 20 beq not taken
    img[32*k +: 32] = encI(6'h08, 0, 30, 16'h0009);        k++; // 21
    img[32*k +: 32] = encB(6'h05, 0, 0, 1);                k++; // 22 bne not taken
    img[32*k +: 32] = encI(6'h08, 0, 31, 16'h1234);        k++; // 23
    img[32*k +: 32] = encI(6'h08, 30, 30, 16'h0001);       k++; // 24 in-place add
    img[32*k +: 32] = encB(6'h05, 30, 0, 1);               k++; // 25 uses fresh r30
    img[32*k +: 32] = encI(6'h08, 0, 29, 16'h0003);        k++; // 26 skipped
    img[32*k +: 32] = encI(6'h0F, 0, T0, GCD_A[31:16]);    k++; // 27
    img[32*k +: 32] = encI(6'h0D, T0, T0, GCD_A[15:0]);    k++; // 28
    img[32*k +: 32] = encI(6'h0F, 0, T1, GCD_B[31:16]);    k++; // 29
    img[32*k +: 32] = encI(6'h0D, T1, T1, GCD_B[15:0]);    k++; // 30
    img[32*k +: 32] = encB(6'h04, T0, 0, 28);              k++; // 31 a==0
    img[32*k +: 32] = encB(6'h04, T1, 0, 28);              k++; // 32 b==0
    img[32*k +: 32] = encI(6'h08, 0, T2, 16'h0000);        k++; // 33 shift=0
    img[32*k +: 32] = encR(T0, T1, T3, 0, 6'h25);          k++; // 34 common
    img[32*k +: 32] = encI(6'h0C, T3, T3, 16'h0001);       k++; // 35
    img[32*k +: 32] = encB(6'h05, T3, 0, 4);               k++; // 36
    img[32*k +: 32] = encR(0, T0, T0, 1, 6'h02);           k++; // 37
    img[32*k +: 32] = encR(0, T1, T1, 1, 6'h02);           k++; // 38
    img[32*k +: 32] = encI(6'h08, T2, T2, 16'h0001);       k++; // 39
    img[32*k +: 32] = encB(6'h04, 0, 0, -7);               k++; // 40
    img[32*k +: 32] = encI(6'h0C, T0, T3, 16'h0001);       k++; // 41 a odd
    img[32*k +: 32] = encB(6'h05, T3, 0, 2);               k++; // 42
    img[32*k +: 32] = encR(0, T0, T0, 1, 6'h02);           k++; // 43
    img[32*k +: 32] = encB(6'h04, 0, 0, -4);               k++; // 44
    img[32*k +: 32] = encI(6'h0C, T1, T3, 16'h0001);       k++; // 45 b odd
    img[32*k +: 32] = encB(6'h05, T3, 0, 2);               k++; // 46
    img[32*k +: 32] = encR(0, T1, T1, 1, 6'h02);           k++; // 47
    img[32*k +: 32] = encB(6'h04, 0, 0, -4);               k++; // 48
    img[32*k +: 32] = encR(T1, T0, T4, 0, 6'h2A);          k++; // 49 b<a
    img[32*k +: 32] = encB(6'h04, T4, 0, 3);               k++; // 50
    img[32*k +: 32] = encR(T0, 0, T3, 0, 6'h25);           k++; // 51 swap
    img[32*k +: 32] = encR(T1, 0, T0, 0, 6'h25);           k++; // 52
    img[32*k +: 32] = encR(T3, 0, T1, 0, 6'h25);           k++; // 53
    img[32*k +: 32] = encR(T1, T0, T1, 0, 6'h22);          k++; // 54 b-=a
    img[32*k +: 32] = encB(6'h05, T1, 0, -11);             k++; // 55
    img[32*k +: 32] = encB(6'h04, T2, 0, 4);               k++; // 56 restore
    img[32*k +: 32] = encR(0, T0, T0, 1, 6'h00);           k++; // 57
    img[32*k +: 32] = encI(6'h18, T2, T2, 16'h0001);       k++; // 58
    img[32*k +: 32] = encB(6'h04, 0, 0, -4);               k++; // 59
    img[32*k +: 32] = encR(T1, 0, T0, 0, 6'h25);           k++; // 60 a was 0
    img[32*k +: 32] = encB(6'h04, T0, T0, -1);             k++; // 61 halt
    return img;
  endfunction

  localparam logic [ROM_WORDS*32-1:0] IMAGE = buildImage();
  localparam logic [31:0] HALT_WORD = 32'h1108FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  dbgSel = '0;
  logic [31:0] pcOut, instrOut, dbgData;

  always #5 clk = ~clk;

  loop_core #(
    .ROM_WORDS (ROM_WORDS),
    .ROM_IMAGE (IMAGE)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .dbgSel   (dbgSel),
    .pcOut    (pcOut),
    .instrOut (instrOut),
    .dbgData  (dbgData)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refGcd(logic [31:0] a, logic [31:0] b);
    logic [31:0] x, y, t;
    x = a; y = b;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  // Scoreboard
  typedef struct {
    int          cyc;
    bit          isReg;
    int          idx;
    logic [31:0] val;
    string       tag;
  } itemT;
  itemT expQ[$];

  task automatic pushPc(int cyc, logic [31:0] val, string tag);
    itemT it;
    it.cyc = cyc; it.isReg = 1'b0; it.idx = 0; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pushReg(int idx, logic [31:0] val, string tag);
    itemT it;
    it.cyc = -1; it.isReg = 1'b1; it.idx = idx; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Driver
  initial begin
    for (int n = 0; n <= 16; n++) begin
      if (n >= 14) pushPc(n, 32'(4 * n), "R10 no-op advances pc");
      else         pushPc(n, 32'(4 * n), "R2 sequential pc");
    end
    pushPc(17, 32'd72,  "R7 bne taken skips next word");
    pushPc(18, 32'd80,  "R7 beq taken skips next word");
    pushPc(19, 32'd84,  "R7 beq not taken");
    pushPc(20, 32'd88,  "R2 after not-taken path");
    pushPc(21, 32'd92,  "R7 bne not taken");
    pushPc(22, 32'd96,  "R2 step");
    pushPc(23, 32'd100, "R2 step");
    pushPc(24, 32'd108, "R7 branch on just-written register");

    pushReg(16, 32'h800000F0, "R6 lui then ori zero-extend");
    pushReg(17, 32'hFFFFFFFB, "R6 addi sign-extend");
    pushReg(18, 32'h0000FFFB, "R6 andi zero-extend");
    pushReg(19, 32'h00000001, "R4 slt signed true");
    pushReg(20, 32'h00000000, "R4 slt signed false");
    pushReg(21, 32'h40000078, "R5 srl one bit logical");
    pushReg(22, 32'h000001E0, "R5 sll one bit");
    pushReg(23, 32'h0000FFF8, "R6 subi");
    pushReg(24, 32'h0000FFFB, "R3 and");
    pushReg(25, 32'h8000FFFB, "R3 or");
    pushReg(26, 32'hFFFF0005, "R3 sub wraps");
    pushReg(27, 32'h000001E0, "R3 add wraps");
    pushReg(0,  32'h00000000, "R9 r0 write dropped");
    pushReg(29, 32'h00000000, "R10 R7 no write from no-op or skipped words");
    pushReg(30, 32'd10,       "R7 in-place add on fall-through path");
    pushReg(31, 32'h00001234, "R7 not-taken bne falls through");
    pushReg(T0, refGcd(GCD_A, GCD_B), "R12 divisor in r8");
    pushReg(T1, 32'h0,        "R12 r9 zero");
    pushReg(T2, 32'h0,        "R12 r10 zero");

    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(pcOut == 32'h0, "R1 reset pc", pcOut, 32'h0);
    check(instrOut == IMAGE[31:0], "R1 R11 reset instruction", instrOut, IMAGE[31:0]);
    dbgSel = 5'd17;
    #1;
    check(dbgData == 32'h0, "R1 reset register", dbgData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  end

  // Monitor
  initial begin
    itemT it;
    int   n;
    @(posedge rstN);
    #1;
    n = 0;
    while (expQ.size() > 0 && !expQ[0].isReg) begin
      while (n < expQ[0].cyc) begin
        @(negedge clk);
        n++;
      end
      it = expQ.pop_front();
      check(pcOut == it.val, it.tag, pcOut, it.val);
    end
    for (int i = 0; i < 20000 && pcOut != HALT_PC; i++) @(negedge clk);
    check(pcOut == HALT_PC, "R12 reached halt word", pcOut, HALT_PC);
    check(instrOut == HALT_WORD, "R11 instruction output at halt", instrOut, HALT_WORD);
    repeat (3) begin
      @(negedge clk);
      check(pcOut == HALT_PC, "R8 pc held by self-branch", pcOut, HALT_PC);
    end
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      dbgSel = it.idx[4:0];
      #1;
      check(dbgData == it.val, it.tag, dbgData, it.val);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog actual=0x%08h expected=0x%08h", pcOut, HALT_PC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule